// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame should be kept. A receiver presents the identifier section of each frame as one 32-bit word together with a one-cycle `frame_valid` strobe. The block compares that word against a 32-bit pattern bank and a 32-bit mask bank. Each bank is loaded as four bytes. A mask bit of 1 turns the matching pattern bit into a don't-care. A two-bit mode reshapes the bank. It can act as one wide filter, two half-width filters or four byte-wide filters, or it can be closed so that no frame is accepted.

When a frame passes, the block raises `accept` for one cycle and sets `rx_full`. It also records in `hit_idx` the filter that matched. When several filters match, the lowest-numbered one is reported. `rx_full` stays set until the host pulses `rx_clear`.

Identifier word layout (bit 31 first): extended frames carry ID28..ID21 in [31:24], ID20..ID18 in [23:21], SRR in [20], IDE in [19], ID17..ID15 in [18:16], ID14..ID0 in [15:1] and RTR in [0]. Standard frames carry ID10..ID0 in [31:21], RTR in [20] and IDE (0) in [19], and bits [15:0] carry nothing. Bank byte 0 aligns with bits [31:24] and byte 3 aligns with bits [7:0].

Top module: `can_id_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `accept`, `rx_full` and `hit_idx` (to 0) at that edge.
- R2: A pattern bit is compared only where its mask bit is 0. A filter matches when every compared pattern bit equals the received bit.
- R3: With `filt_mode` = 2'b00 (single), all 32 bank bits form filter 0 and are compared against the whole word when bit 19 (IDE) is 1. A match reports `hit_idx` = 0.
- R4: In single mode with bit 19 = 0 (standard frame), word bits [15:0] are ignored, and only bits [31:16] are compared.
- R5: With `filt_mode` = 2'b01 (dual), filter 0 is bank bytes 0..1 and filter 1 is bank bytes 2..3. Each is compared against word bits [31:16].
- R6: With `filt_mode` = 2'b10 (quad), filter k is bank byte k, compared against word bits [31:24], for k = 0..3.
- R7: When more than one filter matches, `hit_idx` takes the lowest matching filter number.
- R8: With `filt_mode` = 2'b11 (closed), no frame is accepted.
- R9: `accept` is high for exactly the one cycle after a clock edge at which `frame_valid` was high and some filter matched. Otherwise it is low.
- R10: `rx_full` is set by an accept and holds until an edge with `rx_clear` high and no accept. If an accept and `rx_clear` fall on the same edge, the accept wins.
- R11: `hit_idx` changes only on an accept. A rejected frame leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid | input | 1 | Identifier word valid strobe |
| id_word | input | 32 | Received identifier and control bits |
| filt_mode | input | 2 | 00 single, 01 dual, 10 quad, 11 closed |
| acc_b0 | input | 8 | Pattern byte 0 (aligned with id bits 31:24) |
| acc_b1 | input | 8 | Pattern byte 1 |
| acc_b2 | input | 8 | Pattern byte 2 |
| acc_b3 | input | 8 | Pattern byte 3 |
| msk_b0 | input | 8 | Mask byte 0 (1 = don't care) |
| msk_b1 | input | 8 | Mask byte 1 |
| msk_b2 | input | 8 | Mask byte 2 |
| msk_b3 | input | 8 | Mask byte 3 |
| rx_clear | input | 1 | Host clear of the receive-full flag |
| accept | output | 1 | One-cycle accept pulse |
| rx_full | output | 1 | Receive-full flag |
| hit_idx | output | 2 | Index of the filter that caused the last accept |

## Verification
The hardest case to reach from the ports is a collision between filters: two or more filters must match the same word while a higher-numbered one also matches. Otherwise an error in the priority order stays hidden. The stimulus builds such cases on purpose. It uses a dual-mode bank whose two halves are equal, and a quad-mode bank in which bytes 1 and 3 share one value, so that filters 1 and 3 both hit. It also sends rejected frames straight after accepted ones, so that an index overwritten by a rejection would show up. A final directed case lands an accept on the same edge as `rx_clear`.

// File: rtl/can_filt_pkg.sv
// Package: shared sizes and mode encoding for the acceptance filter.
// Assumes a 32-bit bank built from four bytes, with byte 0 most significant.
package can_filt_pkg;
    localparam int BYTE_W     = 8;
    localparam int BANK_BYTES = 4;
    localparam int BANK_W     = BYTE_W * BANK_BYTES;
    localparam int HALF_W     = BANK_W / 2;
    localparam int NUM_FILT   = BANK_BYTES;
    localparam int IDX_W      = $clog2(NUM_FILT);
    localparam int IDE_BIT    = 19;
    localparam int STD_LOW_W  = 16;

    typedef enum logic [1:0] {
        FM_SINGLE = 2'b00,
        FM_DUAL   = 2'b01,
        FM_QUAD   = 2'b10,
        FM_CLOSED = 2'b11
    } filt_mode_e;
endpackage

// File: rtl/can_filt_cmp.sv
// Masked comparator: reports a match when every bit whose mask is 0
// equals the received bit. Purely combinational.
module can_filt_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] pat,
    input  logic [W-1:0] msk,
    input  logic [W-1:0] rcv,
    output logic         match
);
    // Compare only the unmasked bit positions.
    always_comb match = ~|((pat ^ rcv) & ~msk);
endmodule

// File: rtl/can_filt_lanes.sv
// Filter lanes: builds the single, dual and quad filter sets from the bank
// and selects the hit vector for the active mode. Bit k of hits is filter k.
// Assumes the identifier word layout in which bit IDE_BIT flags extended frames.
module can_filt_lanes
    import can_filt_pkg::*;
(
    input  logic [BANK_W-1:0]   acc_bank,
    input  logic [BANK_W-1:0]   msk_bank,
    input  logic [BANK_W-1:0]   id_word,
    input  filt_mode_e          mode,
    output logic [NUM_FILT-1:0] hits
);
    localparam int NUM_HALF = BANK_W / HALF_W;

    logic [BANK_W-1:0]     single_msk;
    logic                  hit_single;
    logic [NUM_HALF-1:0]   hit_dual;
    logic [NUM_FILT-1:0]   hit_quad;

    // Standard frames carry no identifier in the low bits: force them to don't-care.
    always_comb begin
        single_msk = msk_bank;
        if (!id_word[IDE_BIT])
            single_msk[STD_LOW_W-1:0] = '1;
    end

    can_filt_cmp #(.W(BANK_W)) u_single (
        .pat(acc_bank), .msk(single_msk), .rcv(id_word), .match(hit_single)
    );

    for (genvar g = 0; g < NUM_HALF; g++) begin : g_dual
        can_filt_cmp #(.W(HALF_W)) u_cmp (
            .pat  (acc_bank[BANK_W-1-g*HALF_W -: HALF_W]),
            .msk  (msk_bank[BANK_W-1-g*HALF_W -: HALF_W]),
            .rcv  (id_word[BANK_W-1 -: HALF_W]),
            .match(hit_dual[g])
        );
    end

    for (genvar g = 0; g < NUM_FILT; g++) begin : g_quad
        can_filt_cmp #(.W(BYTE_W)) u_cmp (
            .pat  (acc_bank[BANK_W-1-g*BYTE_W -: BYTE_W]),
            .msk  (msk_bank[BANK_W-1-g*BYTE_W -: BYTE_W]),
            .rcv  (id_word[BANK_W-1 -: BYTE_W]),
            .match(hit_quad[g])
        );
    end

    // Route the hit set of the selected mode; the closed mode yields none.
    always_comb begin
        hits = '0;
        unique case (mode)
            FM_SINGLE: hits[0]            = hit_single;
            FM_DUAL:   hits[NUM_HALF-1:0] = hit_dual;
            FM_QUAD:   hits               = hit_quad;
            default:   hits               = '0;
        endcase
    end
endmodule

// File: rtl/can_filt_prio.sv
// Priority encoder: returns the lowest set index of the hit vector and
// whether any bit is set. Purely combinational.
module can_filt_prio #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  hits,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top so the lowest matching index is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (hits[i]) idx = IW'(i);
        any = |hits;
    end
endmodule

// File: rtl/can_id_filter.sv
// Top: identifier acceptance filter. Assembles the pattern and mask banks,
// evaluates the filters for the selected mode and registers the accept
// pulse, receive-full flag and hit index.
// Assumes frame_valid is a one-cycle strobe and the banks are stable while it is high.
module can_id_filter
    import can_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [31:0]       id_word,
    input  logic [1:0]        filt_mode,
    input  logic [7:0]        acc_b0,
    input  logic [7:0]        acc_b1,
    input  logic [7:0]        acc_b2,
    input  logic [7:0]        acc_b3,
    input  logic [7:0]        msk_b0,
    input  logic [7:0]        msk_b1,
    input  logic [7:0]        msk_b2,
    input  logic [7:0]        msk_b3,
    input  logic              rx_clear,
    output logic              accept,
    output logic              rx_full,
    output logic [1:0]        hit_idx
);
    logic [BANK_W-1:0]   acc_bank;
    logic [BANK_W-1:0]   msk_bank;
    logic [NUM_FILT-1:0] hits;
    logic [IDX_W-1:0]    win_idx;
    logic                any_hit;
    logic                take;

    // Byte 0 of each bank lines up with the top byte of the identifier word.
    always_comb begin
        acc_bank = {acc_b0, acc_b1, acc_b2, acc_b3};
        msk_bank = {msk_b0, msk_b1, msk_b2, msk_b3};
    end

    can_filt_lanes u_lanes (
        .acc_bank(acc_bank),
        .msk_bank(msk_bank),
        .id_word (id_word),
        .mode    (filt_mode_e'(filt_mode)),
        .hits    (hits)
    );

    can_filt_prio #(.N(NUM_FILT)) u_prio (
        .hits(hits),
        .idx (win_idx),
        .any (any_hit)
    );

    // A frame is taken when it is presented and some filter matches.
    always_comb take = frame_valid & any_hit;

    // Register the outputs; an accept outranks a same-cycle host clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept  <= 1'b0;
            rx_full <= 1'b0;
            hit_idx <= '0;
        end else begin
            accept <= take;
            if (take) begin
                rx_full <= 1'b1;
                hit_idx <= win_idx;
            end else if (rx_clear) begin
                rx_full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/can_id_filter_chk.sv
// Checker: temporal properties of the acceptance filter outputs.
// Bound to every instance of the top module.
module can_id_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_valid,
    input logic [1:0] filt_mode,
    input logic       rx_clear,
    input logic       accept,
    input logic       rx_full,
    input logic [1:0] hit_idx
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!accept && !rx_full && hit_idx == 2'd0)); // R1

    AST_ACCEPT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(frame_valid)); // R9

    AST_CLOSED_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && filt_mode == 2'b11) |=> !accept); // R8

    AST_SINGLE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && $past(filt_mode) == 2'b00) |-> hit_idx == 2'd0); // R3

    AST_FULL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> rx_full); // R10

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_clear) |=> rx_full); // R10

    AST_IDX_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> $stable(hit_idx)); // R11
endmodule

bind can_id_filter can_id_filter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_valid(frame_valid),
    .filt_mode  (filt_mode),
    .rx_clear   (rx_clear),
    .accept     (accept),
    .rx_full    (rx_full),
    .hit_idx    (hit_idx)
);

// File: tb/can_id_filter_test.sv
module can_id_filter_test;
    localparam int CLK_P = 10;
    localparam int NV    = 13;
    // {mode[2], acc[32], msk[32], id[32], exp_accept[1], exp_idx[2]}
    localparam logic [100:0] VECS [0:NV-1] = '{
        {2'b00, 32'hABC8_1235, 32'h0000_0000, 32'hABC8_1235, 1'b1, 2'd0}, // R3 exact extended
        {2'b00, 32'hABC8_1235, 32'h0000_0000, 32'hABC8_1234, 1'b0, 2'd0}, // R3 low bit differs
        {2'b00, 32'hABC8_1235, 32'h0000_0001, 32'hABC8_1234, 1'b1, 2'd0}, // R2 masked bit
        {2'b00, 32'hABC0_0000, 32'h0000_0000, 32'hABC0_FFFF, 1'b1, 2'd0}, // R4 standard low ignored
        {2'b00, 32'hABC0_0000, 32'h0000_0000, 32'hABD0_0000, 1'b0, 2'd0}, // R4 high differs
        {2'b01, 32'h1111_2222, 32'h0000_0000, 32'h2222_0000, 1'b1, 2'd1}, // R5 filter 1
        {2'b01, 32'h3333_3333, 32'h0000_0000, 32'h3333_5555, 1'b1, 2'd0}, // R7 both match
        {2'b01, 32'h1111_2222, 32'h0000_0000, 32'h4444_0000, 1'b0, 2'd0}, // R11 reject keeps idx
        {2'b10, 32'h1020_3040, 32'h0000_0000, 32'h4000_0000, 1'b1, 2'd3}, // R6 byte 3
        {2'b10, 32'h1020_3040, 32'h000F_0000, 32'h2A00_0000, 1'b1, 2'd1}, // R2 quad masked
        {2'b10, 32'h7050_6050, 32'h0000_0000, 32'h5000_0000, 1'b1, 2'd1}, // R7 filters 1 and 3
        {2'b11, 32'h5000_0000, 32'hFFFF_FFFF, 32'h5000_0000, 1'b0, 2'd1}, // R8 closed
        {2'b01, 32'hFFFF_1234, 32'h0000_00FF, 32'h12AB_0000, 1'b1, 2'd1}  // R5 masked half
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0;
    logic [31:0] id_word = '0;
    logic [1:0]  filt_mode = 2'b00;
    logic [31:0] acc = '0;
    logic [31:0] msk = '0;
    logic        rx_clear = 1'b0;
    logic        accept;
    logic        rx_full;
    logic [1:0]  hit_idx;
    int          checks = 0;
    int          failures = 0;

    always #(CLK_P/2) clk = ~clk;

    can_id_filter uut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .id_word(id_word),
        .filt_mode(filt_mode),
        .acc_b0(acc[31:24]), .acc_b1(acc[23:16]), .acc_b2(acc[15:8]), .acc_b3(acc[7:0]),
        .msk_b0(msk[31:24]), .msk_b1(msk[23:16]), .msk_b2(msk[15:8]), .msk_b3(msk[7:0]),
        .rx_clear(rx_clear), .accept(accept), .rx_full(rx_full), .hit_idx(hit_idx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one frame; returns at the negedge after the sampling edge.
    task automatic send(input logic [31:0] id);
        @(negedge clk);
        id_word = id;
        frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    task automatic clear_full();
        @(negedge clk);
        rx_clear = 1'b1;
        @(negedge clk);
        rx_clear = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [1:0] exp_idx;
        exp_idx = 2'd0;
        repeat (3) @(negedge clk);
        check("R1 accept", {31'b0, accept}, 0);
        check("R1 rx_full", {31'b0, rx_full}, 0);
        check("R1 hit_idx", {30'b0, hit_idx}, 0);
        rst_n = 1'b1;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            filt_mode = VECS[v][100:99];
            acc       = VECS[v][98:67];
            msk       = VECS[v][66:35];
            if (VECS[v][2]) exp_idx = VECS[v][1:0];
            send(VECS[v][34:3]);
            check($sformatf("R9 accept vec%0d", v), {31'b0, accept}, {31'b0, VECS[v][2]});
            check($sformatf("R11 hit_idx vec%0d", v), {30'b0, hit_idx}, {30'b0, exp_idx});
            check($sformatf("R10 rx_full vec%0d", v), {31'b0, rx_full}, {31'b0, VECS[v][2]});
            @(negedge clk);
            check($sformatf("R9 pulse width vec%0d", v), {31'b0, accept}, 0);
            clear_full();
            check($sformatf("R10 cleared vec%0d", v), {31'b0, rx_full}, 0);
        end

        // R9: matching word without frame_valid is not accepted
        filt_mode = 2'b00; acc = 32'h0000_0000; msk = 32'hFFFF_FFFF;
        id_word = 32'h1234_5678;
        repeat (4) @(negedge clk);
        check("R9 no strobe no accept", {31'b0, accept}, 0);
        check("R9 no strobe no full", {31'b0, rx_full}, 0);

        // R10: flag holds for many cycles without clear
        send(32'h1234_5678);
        check("R10 set", {31'b0, rx_full}, 1);
        repeat (6) @(negedge clk);
        check("R10 holds", {31'b0, rx_full}, 1);

        // R10: accept and clear on the same edge; accept wins
        @(negedge clk);
        frame_valid = 1'b1; rx_clear = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0; rx_clear = 1'b0;
        check("R10 accept beats clear", {31'b0, rx_full}, 1);
        check("R10 accept beats clear pulse", {31'b0, accept}, 1);

        // R8: closed mode rejects an all-don't-care bank; flag untouched
        clear_full();
        filt_mode = 2'b11;
        send(32'h1234_5678);
        check("R8 closed accept", {31'b0, accept}, 0);
        check("R8 closed full", {31'b0, rx_full}, 0);

        // R6 + R7: quad mode with all bytes don't-care reports filter 0
        filt_mode = 2'b10;
        send(32'hFFFF_FFFF);
        check("R7 quad all match idx", {30'b0, hit_idx}, 0);

        // R1: reset mid-run clears state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset full", {31'b0, rx_full}, 0);
        check("R1 mid reset accept", {31'b0, accept}, 0);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule